// File: doc/BRIEF.md
# Write-Protect Silent Discard Filter

This block sits between a storage device's command decoder and the path that carries host write data to the media backend. Shortly after reset it samples a physical write-protect switch through a synchronizer and freezes the result for the rest of the power cycle. Later movement of the switch changes nothing.

While protection is frozen on, the block recognises every data-write opcode and withholds that command from the backend. It accepts each host data beat in the cycle it is offered, throws the data away, and never raises the media write strobe. When the expected number of beats has arrived, it reports completion with a clean status. The host therefore sees an ordinary, successful write at full speed. All other commands, and all commands while unprotected, go straight through to the backend. In that case the backend's completion and error indication is returned to the host unchanged.

The beat count of a write comes with its command. A count of zero stands for the largest transfer, 2^CNT_W beats, which is 256 with the default width.

Top module: `wp_discard_filter`

## Requirements
- R1: `wp_active_o` is 0 while `rst_n` is low. It equals the level that `wp_switch_i` held across the reset release, no later than four rising edges after `rst_n` goes high.
- R2: After it has been captured, `wp_active_o` no longer follows `wp_switch_i`, and neither does the treatment of commands, until the next reset.
- R3: While protected and idle, a command whose opcode is 30h, 31h, 34h, 35h, 39h, 61h, C5h, CAh or CBh is not forwarded: `be_cmd_valid_o` stays 0 in the cycle of `cmd_valid_i`.
- R4: During a discarded write, `host_ready_o` is 1 in every cycle, whatever `media_ready_i` does, so each host beat is accepted in the cycle it is presented.
- R5: During a discarded write, `media_valid_o` stays 0 and `media_data_o` is 0.
- R6: A discarded write ends after exactly N accepted beats, where N is `cmd_count_i`, or 2^CNT_W when that count is 0. In the cycle after the last beat, `cmd_done_o` is 1 for exactly one cycle with `cmd_err_o` 0.
- R7: Other opcodes, and every opcode while unprotected, are forwarded in the same cycle with opcode and count unchanged. The write data path is then direct: `media_valid_o` equals `host_valid_i`, `media_data_o` equals `host_data_i`, and `host_ready_o` equals `media_ready_i`.
- R8: Outside a discarded write, `cmd_done_o` and `cmd_err_o` follow `be_done_i` and `be_done_i & be_err_i` in the same cycle. During a discarded write, `be_done_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_switch_i | input | 1 | Raw write-protect switch level, asynchronous |
| cmd_valid_i | input | 1 | One-cycle command strobe from the decoder |
| cmd_opcode_i | input | 8 | Command opcode |
| cmd_count_i | input | CNT_W | Data beats of the command, 0 meaning 2^CNT_W |
| be_cmd_valid_o | output | 1 | Command strobe to the backend |
| be_cmd_opcode_o | output | 8 | Opcode to the backend |
| be_cmd_count_o | output | CNT_W | Beat count to the backend |
| host_valid_i | input | 1 | Host write data beat present |
| host_data_i | input | DATA_W | Host write data |
| host_ready_o | output | 1 | Beat accepted acknowledgement to the host |
| media_valid_o | output | 1 | Media write strobe |
| media_data_o | output | DATA_W | Media write data |
| media_ready_i | input | 1 | Media ready for a beat |
| be_done_i | input | 1 | Backend command completion |
| be_err_i | input | 1 | Backend error flag, qualified by be_done_i |
| cmd_done_o | output | 1 | Completion to the host side |
| cmd_err_o | output | 1 | Error flag to the host side |
| wp_active_o | output | 1 | Frozen write-protect state |

## Verification
The bench flips the switch after capture and expects both the protection flag and command handling to stay put. A latch that kept tracking the switch, or one that captured the synchronizer's reset value, would show the wrong state. Every write opcode is sent with the media held not-ready and a backend completion forced during the transfer. A filter that missed an opcode, throttled the host, leaked a media strobe or passed a stray completion would show up at the ports.

Completion is checked to come exactly one cycle after the last beat, including the zero-count case of 256 beats. An off-by-one beat counter would finish early or late. Near-miss opcodes such as 60h and ordinary reads are checked for being forwarded with the backend's error passed through.

// File: rtl/wp_filter_pkg.sv
package wp_filter_pkg;

  typedef enum logic [0:0] {
    DROP_IDLE = 1'b0,
    DROP_BUSY = 1'b1
  } drop_state_e;

  // Opcodes that carry host data towards the media
  function automatic logic op_is_write(input logic [7:0] op);
    case (op)
      8'h30, 8'h31, 8'h34, 8'h35, 8'h39,
      8'h61, 8'hC5, 8'hCA, 8'hCB: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wp_switch_latch.sv
module wp_switch_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic switch_i,
  output logic protect_o
);
  localparam int SETTLE_W = $clog2(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SETTLE_W-1:0]    settle_q, settle_d;
  logic                   locked_q, locked_d;
  logic                   prot_q, prot_d;
  logic                   capture;

  assign capture = !locked_q && (settle_q == SETTLE_W'(SYNC_STAGES));

  always_comb begin
    sync_d   = {sync_q[SYNC_STAGES-2:0], switch_i};
    settle_d = settle_q;
    locked_d = locked_q;
    prot_d   = prot_q;
    if (!locked_q && !capture) settle_d = settle_q + SETTLE_W'(1);
    if (capture) begin
      locked_d = 1'b1;
      prot_d   = sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      settle_q <= '0;
      locked_q <= 1'b0;
      prot_q   <= 1'b0;
    end else begin
      sync_q <= sync_d;
      if (!locked_q) begin
        settle_q <= settle_d;
        locked_q <= locked_d;
      end
      if (capture) prot_q <= prot_d;
    end
  end

  assign protect_o = prot_q;
endmodule

// File: rtl/wp_drop_fsm.sv
module wp_drop_fsm
  import wp_filter_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             beat_i,
  output logic             active_o,
  output logic             done_o
);
  drop_state_e      state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             left_en;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    left_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      DROP_IDLE: begin
        if (start_i) begin
          state_d = DROP_BUSY;
          left_d  = count_i - CNT_W'(1);
          left_en = 1'b1;
        end
      end
      DROP_BUSY: begin
        if (beat_i) begin
          if (left_q == '0) begin
            state_d = DROP_IDLE;
            done_d  = 1'b1;
          end else begin
            left_d  = left_q - CNT_W'(1);
            left_en = 1'b1;
          end
        end
      end
      default: state_d = DROP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DROP_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (left_en) left_q <= left_d;
    end
  end

  assign active_o = (state_q == DROP_BUSY);
  assign done_o   = done_q;
endmodule

// File: rtl/wp_discard_filter.sv
module wp_discard_filter
  import wp_filter_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_switch_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_opcode_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  output logic              be_cmd_valid_o,
  output logic [7:0]        be_cmd_opcode_o,
  output logic [CNT_W-1:0]  be_cmd_count_o,
  input  logic              host_valid_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic              host_ready_o,
  output logic              media_valid_o,
  output logic [DATA_W-1:0] media_data_o,
  input  logic              media_ready_i,
  input  logic              be_done_i,
  input  logic              be_err_i,
  output logic              cmd_done_o,
  output logic              cmd_err_o,
  output logic              wp_active_o
);
  logic protect;
  logic discarding;
  logic drop_start;
  logic drop_beat;
  logic drop_done;

  wp_switch_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .switch_i  (wp_switch_i),
    .protect_o (protect)
  );

  assign drop_start = cmd_valid_i && protect && !discarding && op_is_write(cmd_opcode_i);
  assign drop_beat  = discarding && host_valid_i;

  wp_drop_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (drop_start),
    .count_i  (cmd_count_i),
    .beat_i   (drop_beat),
    .active_o (discarding),
    .done_o   (drop_done)
  );

  // Command path towards the backend
  assign be_cmd_valid_o  = cmd_valid_i && !drop_start;
  assign be_cmd_opcode_o = cmd_opcode_i;
  assign be_cmd_count_o  = cmd_count_i;

  // Data path: sink locally while discarding, otherwise straight through
  assign host_ready_o  = discarding ? 1'b1 : media_ready_i;
  assign media_valid_o = host_valid_i && !discarding;
  assign media_data_o  = discarding ? '0 : host_data_i;

  // Completion: local clean finish or backend passthrough
  assign cmd_done_o  = drop_done || (be_done_i && !discarding);
  assign cmd_err_o   = !drop_done && be_done_i && be_err_i && !discarding;
  assign wp_active_o = protect;
endmodule

// File: rtl/wp_discard_filter_chk.sv
module wp_discard_filter_chk
  import wp_filter_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_opcode_i,
  input logic       be_cmd_valid_o,
  input logic       host_valid_i,
  input logic       host_ready_o,
  input logic       media_valid_o,
  input logic       media_ready_i,
  input logic       cmd_done_o,
  input logic       cmd_err_o,
  input logic       wp_active_o,
  input logic       discarding
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
  end

  // R1: protection reads low while reset is held
  always_comb begin
    if (!rst_n) a_reset_low_r1: assert (!wp_active_o);
  end

  // R2: frozen once captured
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd4) |-> $stable(wp_active_o));

  // R3: protected write opcode is withheld and starts a discard
  p_withhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && wp_active_o && !discarding && op_is_write(cmd_opcode_i))
      |-> !be_cmd_valid_o);
  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && wp_active_o && !discarding && op_is_write(cmd_opcode_i))
      |=> discarding);

  // R4: host never stalled while discarding
  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    discarding |-> host_ready_o);

  // R5: no media strobe while discarding
  p_no_media_r5: assert property (@(posedge clk) disable iff (!rst_n)
    discarding |-> !media_valid_o);

  // R6: leaving a discard yields a clean completion
  p_clean_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discarding) |-> (cmd_done_o && !cmd_err_o));

  // R7: unprotected or non-write traffic goes straight through
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !discarding |-> (media_valid_o == host_valid_i) && (host_ready_o == media_ready_i));
endmodule

bind wp_discard_filter wp_discard_filter_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_opcode_i   (cmd_opcode_i),
  .be_cmd_valid_o (be_cmd_valid_o),
  .host_valid_i   (host_valid_i),
  .host_ready_o   (host_ready_o),
  .media_valid_o  (media_valid_o),
  .media_ready_i  (media_ready_i),
  .cmd_done_o     (cmd_done_o),
  .cmd_err_o      (cmd_err_o),
  .wp_active_o    (wp_active_o),
  .discarding     (discarding)
);

// File: tb/wp_discard_filter_bench.sv
module wp_discard_filter_bench;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int NVEC   = 15;

  // {is_write, opcode, beat count}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h30, 8'd3}, {1'b1, 8'h31, 8'd1}, {1'b1, 8'h34, 8'd2},
    {1'b1, 8'h35, 8'd4}, {1'b1, 8'h39, 8'd2}, {1'b1, 8'h61, 8'd3},
    {1'b1, 8'hC5, 8'd1}, {1'b1, 8'hCA, 8'd2}, {1'b1, 8'hCB, 8'd5},
    {1'b0, 8'h20, 8'd1}, {1'b0, 8'h25, 8'd2}, {1'b0, 8'hC8, 8'd1},
    {1'b0, 8'hEC, 8'd1}, {1'b0, 8'h60, 8'd3}, {1'b0, 8'h00, 8'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wp_switch_i;
  logic              cmd_valid_i;
  logic [7:0]        cmd_opcode_i;
  logic [CNT_W-1:0]  cmd_count_i;
  logic              be_cmd_valid_o;
  logic [7:0]        be_cmd_opcode_o;
  logic [CNT_W-1:0]  be_cmd_count_o;
  logic              host_valid_i;
  logic [DATA_W-1:0] host_data_i;
  logic              host_ready_o;
  logic              media_valid_o;
  logic [DATA_W-1:0] media_data_o;
  logic              media_ready_i;
  logic              be_done_i;
  logic              be_err_i;
  logic              cmd_done_o;
  logic              cmd_err_o;
  logic              wp_active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wp_discard_filter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_wp_discard_filter (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic power_up(input logic sw);
    @(negedge clk);
    rst_n = 1'b0; wp_switch_i = sw;
    cmd_valid_i = 0; host_valid_i = 0; media_ready_i = 0; be_done_i = 0; be_err_i = 0;
    repeat (3) @(negedge clk);
    #1 chk(wp_active_o == 1'b0, "R1 reset value", wp_active_o, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(wp_active_o == sw, "R1 captured level", wp_active_o, sw);
    wp_switch_i = ~sw;
    repeat (4) @(negedge clk);
    #1 chk(wp_active_o == sw, "R2 frozen after switch flip", wp_active_o, sw);
  endtask

  task automatic run_write(input logic [7:0] op, input logic [CNT_W-1:0] cnt, input bit prot);
    int beats;
    beats = (cnt == 0) ? (1 << CNT_W) : int'(cnt);
    @(negedge clk);
    cmd_valid_i = 1; cmd_opcode_i = op; cmd_count_i = cnt;
    #1;
    if (prot) chk(be_cmd_valid_o == 1'b0, "R3 write withheld", be_cmd_valid_o, 0);
    else begin
      chk(be_cmd_valid_o == 1'b1, "R7 write forwarded", be_cmd_valid_o, 1);
      chk(be_cmd_opcode_o == op && be_cmd_count_o == cnt, "R7 opcode/count", be_cmd_opcode_o, op);
    end
    @(negedge clk);
    cmd_valid_i = 0;
    for (int i = 0; i < beats; i++) begin
      host_valid_i = 1; host_data_i = {op, 8'h5A, 16'(i)};
      media_ready_i = prot ? 1'b0 : 1'b1;
      be_done_i = prot;
      #1;
      if (prot) begin
        chk(host_ready_o == 1'b1, "R4 host ready", host_ready_o, 1);
        chk(media_valid_o == 1'b0 && media_data_o == '0, "R5 no media write", media_valid_o, 0);
        chk(cmd_done_o == 1'b0, "R8 backend done ignored / R6 not early", cmd_done_o, 0);
      end else begin
        chk(host_ready_o == media_ready_i, "R7 ready passthrough", host_ready_o, media_ready_i);
        chk(media_valid_o == 1'b1 && media_data_o == host_data_i, "R7 data passthrough",
            media_data_o, host_data_i);
      end
      @(negedge clk);
    end
    host_valid_i = 0; be_done_i = 0; media_ready_i = 0;
    if (prot) begin
      #1 chk(cmd_done_o == 1'b1 && cmd_err_o == 1'b0, "R6 clean completion",
             {cmd_done_o, cmd_err_o}, 2'b10);
      @(negedge clk);
      #1 chk(cmd_done_o == 1'b0, "R6 single pulse", cmd_done_o, 0);
    end else begin
      be_done_i = 1; be_err_i = op[0];
      #1 chk(cmd_done_o == 1'b1 && cmd_err_o == op[0], "R8 backend status",
             {cmd_done_o, cmd_err_o}, {1'b1, op[0]});
      @(negedge clk);
      be_done_i = 0; be_err_i = 0;
    end
  endtask

  task automatic run_other(input logic [7:0] op, input logic [CNT_W-1:0] cnt, input logic err);
    @(negedge clk);
    cmd_valid_i = 1; cmd_opcode_i = op; cmd_count_i = cnt;
    #1 chk(be_cmd_valid_o == 1'b1 && be_cmd_opcode_o == op, "R7 non-write forwarded",
           {be_cmd_valid_o, be_cmd_opcode_o}, {1'b1, op});
    @(negedge clk);
    cmd_valid_i = 0; be_done_i = 1; be_err_i = err;
    #1 chk(cmd_done_o == 1'b1 && cmd_err_o == err, "R8 status passthrough",
           {cmd_done_o, cmd_err_o}, {1'b1, err});
    @(negedge clk);
    be_done_i = 0; be_err_i = 0;
  endtask

  task automatic walk_table(input bit prot);
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][16]) run_write(VEC[i][15:8], VEC[i][7:0], prot);
      else            run_other(VEC[i][15:8], VEC[i][7:0], 1'(i));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cmd_opcode_i = 0; cmd_count_i = 0; host_data_i = 0;
    // Unprotected power cycle: switch flips high afterwards (R2)
    power_up(1'b0);
    walk_table(1'b0);
    // Protected power cycle: switch flips low afterwards (R2)
    power_up(1'b1);
    walk_table(1'b1);
    // R6: zero count means the full 256-beat transfer
    run_write(8'h34, 8'd0, 1'b1);
    #1 chk(wp_active_o == 1'b1, "R2 still protected", wp_active_o, 1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule